// File: doc/BRIEF.md
# Prescaled Full-Duplex SPI Master

This block is a serial-peripheral master that software drives through three small registers: a control word, a status word and a data port. The control word turns the block on, selects master operation, picks a power-of-two clock divider applied to the system clock, and sets the bit order and frame width. It also chooses between an external slave-select input and a software-held value, and can tristate the serial output so that the block only receives.

A word written to the data port goes into a single-entry holding buffer. When the shift engine is free, the word moves to the engine, and the buffer reports empty again. Software can therefore queue the next word while the current one is still shifting, and consecutive frames leave the wire with no idle clock between them. Each frame is exchanged in full duplex. The frame received last can be read from the data port, and that read clears the receive flag. The serial clock idles low. Output data changes on its falling edge and input data is sampled on its rising edge.

Top module: `spi_prescaled_master`

## Requirements
- R1: After reset the control word reads 0, the status word reads 1 (only tx-empty set), `sck` is low and `mosi_oe` is low.
- R2: The control field at bits [4:2] holds a code c in 0..7. Every SCK half period lasts 2^c clock cycles, so SCK runs at the clock rate divided by 2^(c+1), and this spacing stays uniform across a frame.
- R3: SCK idles low. `mosi` changes only on a falling SCK edge, and `miso` is sampled on the rising edge.
- R4: Control bit 5 selects the bit order: 0 sends the most significant bit first, 1 sends the least significant bit first. The same order is used to place received bits.
- R5: Control bit 6 selects the frame width: 0 gives 8-bit frames, using data bits [7:0], and 1 gives 16-bit frames.
- R6: When a frame finishes, the received word is readable at address 2, and status bit 2 (rx-full) is set. A read at address 2 with `reg_rd` clears status bit 2.
- R7: Status bit 0 (tx-empty) clears on a data write at address 2. The buffered word starts shifting on the next clock if the engine is free, and tx-empty sets again. A data write while tx-empty is 0 is ignored.
- R8: A word buffered before the current frame ends starts on the clock where that frame's last falling SCK edge occurs, so SCK spacing stays uniform between frames.
- R9: Status bit 1 (busy) stays set until the last queued frame's final falling SCK edge, and it reads 0 on the cycle that follows that edge.
- R10: Control bit 7 set makes control bit 8 the effective slave-select, and the `ss_in_n` pin is ignored. With bit 7 clear, `ss_in_n` is used. No new frame starts while the effective slave-select is low.
- R11: Control bit 9 set drives `mosi_oe` low, giving receive-only operation. With bit 9 clear and bits 0 and 1 set, `mosi_oe` is high.
- R12: A control write made while busy leaves the master bit (bit 1) unchanged. No frame starts while the master bit is 0.
- R13: Clearing the enable bit (bit 0) stops the engine on the next clock. SCK goes low, busy clears and the prescaler restarts from zero. A buffered word is kept and starts once the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the read side effect) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| ss_in_n | input | 1 | External slave-select input |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for `mosi` |

## Verification
The bench builds the block with its default parameters: a 3-bit divider code, 16-bit wide frames and 8-bit narrow frames. These defaults put every prescaler code from a one-cycle to a 128-cycle half period within reach, along with both frame widths and both bit orders. The bench runs a bit-level slave model that records the MOSI and MISO bits at each rising SCK edge and the clock cycle of each SCK edge. Randomly chosen divider codes, orders, widths and data run beside directed cases: queued back-to-back words, a third write that must be dropped, blocking by the slave-select pin, a master-bit change while busy, and disabling the block mid-frame.

// File: rtl/spi_prescaled_master.sv
`timescale 1ns/1ps
module spi_prescaled_master #(
  parameter int DIV_W    = 3,
  parameter int FRAME_W  = 16,
  parameter int NARROW_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [FRAME_W-1:0] reg_wdata,
  output logic [FRAME_W-1:0] reg_rdata,
  input  logic               ss_in_n,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               mosi_oe
);
  localparam int CNT_W  = (1 << DIV_W) - 1;
  localparam int IDX_W  = $clog2(FRAME_W);
  localparam int P_LSB  = 2 + DIV_W;
  localparam int P_WIDE = P_LSB + 1;
  localparam int P_SSM  = P_WIDE + 1;
  localparam int P_SSV  = P_SSM + 1;
  localparam int P_RXO  = P_SSV + 1;
  localparam int CTRL_W = P_RXO + 1;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic [CTRL_W-1:0]  ctrl;
  logic [FRAME_W-1:0] txbuf, shreg, rxsh, rxdata;
  logic               tx_full, rx_full, busy, sck_q, f_lsb, f_wide;
  logic [IDX_W-1:0]   bitcnt;
  logic [CNT_W-1:0]   cnt;

  wire             en     = ctrl[0];
  wire             mstr   = ctrl[1];
  wire [DIV_W-1:0] div    = ctrl[2 +: DIV_W];
  wire             ss_eff = ctrl[P_SSM] ? ctrl[P_SSV] : ss_in_n;
  wire             go     = en & mstr & ss_eff;

  wire [CNT_W:0]   half   = (CNT_W+1)'(1) << div;
  wire             tick   = ({1'b0, cnt} >= half - 1'b1);
  wire [IDX_W-1:0] last   = f_wide ? IDX_W'(FRAME_W-1) : IDX_W'(NARROW_W-1);
  wire [IDX_W-1:0] idx    = f_lsb ? bitcnt : last - bitcnt;

  wire frame_end = busy & tick & sck_q & (bitcnt == last);
  wire load      = go & tx_full & (~busy | frame_end);
  wire wr_ctrl   = reg_wr & (reg_addr == A_CTRL);
  wire wr_data   = reg_wr & (reg_addr == A_DATA);
  wire rd_data   = reg_rd & (reg_addr == A_DATA);

  assign sck     = sck_q;
  assign mosi    = busy & shreg[idx];
  assign mosi_oe = en & mstr & ~ctrl[P_RXO];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = FRAME_W'(ctrl);
      A_STAT:  reg_rdata = FRAME_W'({rx_full, busy, ~tx_full});
      A_DATA:  reg_rdata = rxdata;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; txbuf <= '0; shreg <= '0; rxsh <= '0; rxdata <= '0;
      tx_full <= 1'b0; rx_full <= 1'b0; busy <= 1'b0; sck_q <= 1'b0;
      f_lsb <= 1'b0; f_wide <= 1'b0; bitcnt <= '0; cnt <= '0;
    end else begin
      if (wr_ctrl)
        ctrl <= {reg_wdata[CTRL_W-1:2], busy ? mstr : reg_wdata[1], reg_wdata[0]};

      if (load) tx_full <= 1'b0;
      else if (wr_data && !tx_full) begin
        txbuf   <= reg_wdata;
        tx_full <= 1'b1;
      end

      if (frame_end) begin
        rxdata  <= rxsh;
        rx_full <= 1'b1;
      end else if (rd_data) rx_full <= 1'b0;

      if (!en) begin
        busy <= 1'b0; sck_q <= 1'b0; cnt <= '0; bitcnt <= '0;
      end else if (load) begin
        busy <= 1'b1; sck_q <= 1'b0; cnt <= '0; bitcnt <= '0;
        shreg <= txbuf; rxsh <= '0;
        f_lsb <= ctrl[P_LSB]; f_wide <= ctrl[P_WIDE];
      end else if (busy) begin
        if (tick) begin
          cnt   <= '0;
          sck_q <= ~sck_q;
          if (!sck_q) rxsh[idx] <= miso;
          else if (bitcnt == last) busy <= 1'b0;
          else bitcnt <= bitcnt + 1'b1;
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  a_r1_sck_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_q);
  a_r3_mosi_held_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q && $past(sck_q) |-> $stable(mosi));
  a_r2_count_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $stable(div) |-> ({1'b0, cnt} < half));
  a_r6_rx_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $fell(sck_q));
  a_r7_buffer_drains: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !busy && go |=> busy && !tx_full);
  a_r9_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && en |-> $past(sck_q));
  a_r12_master_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mstr));
  a_r13_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy && !sck_q);
endmodule

// File: tb/spi_prescaled_master_test.sv
`timescale 1ns/1ps
module spi_prescaled_master_test;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, ss_in_n = 1, miso = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  wire [15:0] reg_rdata;
  wire sck, mosi, mosi_oe;

  spi_prescaled_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_in_n(ss_in_n),
    .miso(miso), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe));

  int checks = 0, fails = 0, cyc = 0, ln = 0, ne = 0, idle_cyc = 0;
  bit done = 0;
  logic [63:0] lmosi = 0, lmiso = 0;
  logic [31:0] mstream = 0;
  int edges [128];

  always #2.5 clk = ~clk;
  always @(posedge clk) #1 cyc++;
  always @(posedge sck) begin
    if (ln < 64) begin lmosi[ln] = mosi; lmiso[ln] = miso; end
    ln++;
    if (ne < 128) edges[ne] = cyc;
    ne++;
  end
  always @(negedge sck) begin
    mstream = mstream << 1;
    miso = mstream[31];
    if (ne < 128) edges[ne] = cyc;
    ne++;
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit en, bit m, int code, bit lsb, bit wide, bit ssm, bit ssv, bit rxo);
    return {6'd0, rxo, ssv, ssm, wide, lsb, 3'(code), m, en};
  endfunction

  function automatic logic [15:0] assemble(logic [63:0] bits, int base, int n, bit lsb);
    logic [15:0] r = 0;
    for (int k = 0; k < n; k++) r[lsb ? k : n-1-k] = bits[base+k];
    return r;
  endfunction

  function automatic logic [15:0] exp_rx(logic [31:0] s, int n, bit lsb);
    logic [15:0] r = 0;
    for (int k = 0; k < n; k++) r[lsb ? k : n-1-k] = s[31-k];
    return r;
  endfunction

  function automatic int bad_gaps(int half);
    int b = 0;
    for (int i = 0; i + 1 < ne && i + 1 < 128; i++) if (edges[i+1] - edges[i] != half) b++;
    return b;
  endfunction

  task automatic clr(logic [31:0] s);
    ln = 0; ne = 0; lmosi = 0; lmiso = 0; mstream = s; miso = s[31];
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk); reg_addr = 2; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do begin @(negedge clk); rd(1, s); end while (s[1] || !s[0]);
    idle_cyc = cyc;
  endtask

  task automatic run_frame(int code, bit lsb, bit wide, logic [15:0] data, logic [31:0] s);
    logic [15:0] d;
    int n = wide ? 16 : 8;
    wr(0, mk(1, 1, code, lsb, wide, 1, 1, 0));
    clr(s);
    wr(2, data);
    wait_idle();
    check("R5", "bit count", ln, n);
    check("R4", "sent word", assemble(lmosi, 0, n, lsb), wide ? data : {8'd0, data[7:0]});
    check("R2", "uneven sck spacing", bad_gaps(1 << code), 0);
    check("R9", "busy end cycle", idle_cyc, edges[2*n-1] + 1);
    pop(d);
    check("R6", "received word", d, exp_rx(s, n, lsb));
    rd(1, d);
    check("R6", "rx flag after read", d[2], 0);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); check("R1", "control after reset", d, 0);
    rd(1, d); check("R1", "status after reset", d, 1);
    check("R1", "sck after reset", sck, 0);
    check("R1", "mosi_oe after reset", mosi_oe, 0);

    wr(0, mk(1, 1, 2, 0, 0, 1, 1, 0));
    check("R11", "oe driving", mosi_oe, 1);
    clr(32'hC3C3_0000);
    wr(2, 16'h00B7);
    rd(1, d); check("R7", "tx-empty and busy after write", d[1:0], 2'b00);
    @(negedge clk);
    rd(1, d); check("R7", "buffer moved to engine", d[1:0], 2'b11);
    wait_idle();
    pop(d);

    for (int i = 0; i < 16; i++)
      run_frame($urandom % 5, $urandom % 2, $urandom % 2, 16'($urandom), $urandom);
    run_frame(7, 0, 0, 16'h00A5, 32'h5A00_0000);
    run_frame(0, 1, 1, 16'h8001, 32'hF00F_1234);
    run_frame(3, 1, 0, 16'hFF80, 32'h0100_0000);

    wr(0, mk(1, 1, 1, 0, 0, 1, 1, 0));
    clr(32'hA5C3_0000);
    wr(2, 16'h0096);
    do begin @(negedge clk); rd(1, d); end while (!d[0]);
    wr(2, 16'h003C);
    wr(2, 16'h00FF);
    wait_idle();
    check("R7", "frames sent with third write dropped", ln, 16);
    check("R8", "first queued word", assemble(lmosi, 0, 8, 0), 16'h96);
    check("R8", "second queued word", assemble(lmosi, 8, 8, 0), 16'h3C);
    check("R8", "gap between frames", bad_gaps(2), 0);
    check("R9", "busy through both frames", idle_cyc, edges[31] + 1);
    pop(d);
    check("R6", "last frame received", d, 16'h00C3);

    wr(0, mk(1, 1, 0, 0, 0, 0, 0, 0));
    ss_in_n = 0;
    clr(0);
    wr(2, 16'h0033);
    repeat (40) @(negedge clk);
    check("R10", "pin low blocks start", ne, 0);
    ss_in_n = 1;
    wait_idle();
    check("R10", "starts after pin high", assemble(lmosi, 0, 8, 0), 16'h33);
    pop(d);
    ss_in_n = 0;
    wr(0, mk(1, 1, 0, 0, 0, 1, 1, 0));
    clr(0);
    wr(2, 16'h0044);
    wait_idle();
    check("R10", "pin ignored with software select", ln, 8);
    pop(d);
    ss_in_n = 1;
    wr(0, mk(1, 1, 0, 0, 0, 1, 0, 0));
    clr(0);
    wr(2, 16'h0055);
    repeat (40) @(negedge clk);
    check("R10", "software select low blocks", ne, 0);
    wr(0, mk(1, 1, 0, 0, 0, 1, 1, 0));
    wait_idle();
    check("R10", "word after release", assemble(lmosi, 0, 8, 0), 16'h55);
    pop(d);

    wr(0, mk(1, 1, 0, 0, 0, 1, 1, 1));
    check("R11", "receive-only oe", mosi_oe, 0);

    wr(0, mk(1, 1, 5, 0, 0, 1, 1, 0));
    wr(2, 16'h0011);
    repeat (100) @(negedge clk);
    wr(0, mk(1, 0, 5, 0, 0, 1, 1, 0));
    rd(0, d); check("R12", "master kept while busy", d[1], 1);
    wait_idle();
    pop(d);
    wr(0, mk(1, 0, 5, 0, 0, 1, 1, 0));
    rd(0, d); check("R12", "master cleared when idle", d[1], 0);
    clr(0);
    wr(2, 16'h0022);
    repeat (60) @(negedge clk);
    check("R12", "no frame without master", ne, 0);
    wr(0, mk(1, 1, 0, 0, 0, 1, 1, 0));
    wait_idle();
    check("R12", "queued word after master set", assemble(lmosi, 0, 8, 0), 16'h22);
    pop(d);

    wr(0, mk(1, 1, 7, 0, 0, 1, 1, 0));
    clr(0);
    wr(2, 16'h003C);
    repeat (300) @(negedge clk);
    check("R13", "frame running before disable", ne > 0, 1);
    wr(0, mk(0, 1, 7, 0, 0, 1, 1, 0));
    @(negedge clk);
    check("R13", "sck low after disable", sck, 0);
    rd(1, d); check("R13", "idle after disable", d[1:0], 2'b01);
    clr(32'h9900_0000);
    wr(2, 16'h005A);
    repeat (50) @(negedge clk);
    check("R13", "no edges while disabled", ne, 0);
    rd(1, d); check("R13", "word held while disabled", d[1:0], 2'b00);
    wr(0, mk(1, 1, 0, 0, 0, 1, 1, 0));
    wait_idle();
    check("R13", "held word sent", assemble(lmosi, 0, 8, 0), 16'h5A);
    check("R13", "prescaler restarted", bad_gaps(1), 0);
    pop(d);
    check("R6", "receive after restart", d, 16'h0099);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule